// File: doc/BRIEF.md
# Shared-Prescaler Timer and Watchdog

This block combines an 8-bit up-counting timer with a watchdog counter. The two share one 8-bit prescaler, and a single mode bit decides which side receives it. The timer counts either instruction-cycle ticks or edges seen on an external count pin. That pin passes through a two-stage synchronizer, and a mode bit picks whether rising or falling transitions count. The watchdog counts a slow free-running tick, which keeps running while the core sleeps. After a parameterised number of tick events it raises a one-cycle time-out pulse, which a reset controller can use as a reset request.

The mode word is write-only. Software sets it through a write strobe and reads its effect only through the timer's behaviour. A clear-watchdog strobe and a sleep-entry strobe both restart the watchdog count. A bus write to the timer loads a new value. The parameter `WDT_BASE` sets the unprescaled watchdog period as a count of slow ticks. This lets a real design set it to match 18 ms while a bench uses a small value.

Top module: `tmr_wdt_top`

## Requirements
- R1: After reset the timer reads 0x00, no time-out is signalled, and the mode is all ones: external source, falling edge, prescaler on the watchdog, select code 7. Instruction-cycle ticks alone then leave the timer unchanged.
- R2: With mode bit 5 at 0 the timer advances on instruction-cycle ticks. With bit 3 at 1 it advances by one on every such tick.
- R3: With mode bit 5 at 1 the timer counts transitions of the external pin after a two-flop synchronizer. Mode bit 4 at 0 selects rising transitions and at 1 selects falling transitions.
- R4: With mode bit 3 at 0 the timer advances once per 2^(code+1) source events, where code is mode bits 2:0 (1:2 up to 1:256).
- R5: With mode bit 3 at 1 the watchdog advances once per 2^code enabled slow ticks (1:1 up to 1:128), and the timer is not prescaled.
- R6: A timer write loads the written value on the next clock and takes priority over counting. While the prescaler is on the timer, the write also clears the prescaler. The timer wraps from 0xFF to 0x00.
- R7: With the watchdog enabled, the time-out pulse is high for exactly one cycle after `WDT_BASE` watchdog events (prescaled as in R5), and the count then starts again.
- R8: The clear-watchdog strobe and the sleep strobe each zero the watchdog count. When the prescaler is on the watchdog they also zero the prescaler, so the next time-out comes a full period later. With the enable low the watchdog neither counts nor times out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_tick | input | 1 | Instruction-cycle tick, one clock wide |
| ext_pin | input | 1 | Asynchronous external count pin |
| wdt_tick | input | 1 | Slow watchdog tick, one clock wide |
| wdt_en | input | 1 | Watchdog enable |
| wdt_clr | input | 1 | Clear-watchdog strobe |
| sleep_req | input | 1 | Sleep-entry strobe |
| mode_we | input | 1 | Mode word write strobe |
| mode_wdata | input | 6 | Mode word: [5] source, [4] edge, [3] assign, [2:0] code |
| tmr_we | input | 1 | Timer write strobe |
| tmr_wdata | input | 8 | Timer write value |
| tmr_q | output | 8 | Timer value |
| wdt_timeout | output | 1 | One-cycle watchdog time-out pulse |

## Verification
The hardest case to reach is a time-out at the largest watchdog ratio that is measured from a known instant. The watchdog count and the prescaler phase cannot be observed at the ports. The stimulus therefore issues a clear or sleep strobe with the prescaler on the watchdog, and then counts slow ticks until the pulse. This is done once from a fresh clear and once after a partial period, so a leftover prescaler phase would shift the result. A long random phase then mixes mode rewrites, timer writes, clears and pin toggles against a behavioural model that is compared on every clock.

// File: rtl/tw_pkg.sv
package tw_pkg;
  // Mode word, bit 5 down to bit 0
  typedef struct packed {
    logic       src_ext;    // 1: external pin, 0: instruction cycles
    logic       edge_fall;  // 1: falling transitions, 0: rising
    logic       ps_to_wdt;  // 1: prescaler on watchdog, 0: on timer
    logic [2:0] ps_sel;     // ratio select code
  } tw_mode_t;

  localparam tw_mode_t TW_MODE_RST = '{src_ext: 1'b1, edge_fall: 1'b1,
                                       ps_to_wdt: 1'b1, ps_sel: 3'b111};
endpackage

// File: rtl/tw_edge_sync.sv
module tw_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  input  logic fall_sel,
  output logic edge_evt
);
  logic [2:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[1:0], pin_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 3'b000;
    else        sh_q <= sh_d;
  end

  // sh_q[1] is the synchronized level, sh_q[2] its previous value
  assign edge_evt = fall_sel ? (~sh_q[1] & sh_q[2]) : (sh_q[1] & ~sh_q[2]);
endmodule

// File: rtl/tw_prescaler.sv
module tw_prescaler #(
  parameter int PS_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic       clr,
  input  logic [2:0] sel,
  input  logic       wdt_side,
  output logic       fire
);
  localparam int AW = $clog2(PS_W + 1);

  logic [PS_W-1:0] cnt_q, cnt_d;
  logic [AW-1:0]   amt;
  logic [PS_W:0]   full;
  logic [PS_W-1:0] mask;

  always_comb begin
    amt  = AW'(sel) + AW'(!wdt_side);
    full = ({{PS_W{1'b0}}, 1'b1} << amt) - {{PS_W{1'b0}}, 1'b1};
    mask = full[PS_W-1:0];
    fire = adv && ((cnt_q & mask) == mask);
    if (clr)      cnt_d = '0;
    else if (adv) cnt_d = cnt_q + 1'b1;
    else          cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tw_wdt.sv
module tw_wdt #(
  parameter int BASE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic evt,
  input  logic clr,
  output logic timeout
);
  localparam int CW = (BASE > 1) ? $clog2(BASE) : 1;
  localparam logic [CW-1:0] LAST = CW'(BASE - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          to_d;

  always_comb begin
    cnt_d = cnt_q;
    to_d  = 1'b0;
    if (clr || !en) begin
      cnt_d = '0;
    end else if (evt) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        to_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      timeout <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      timeout <= to_d;
    end
  end
endmodule

// File: rtl/tmr_wdt_top.sv
module tmr_wdt_top #(
  parameter int TW       = 8,
  parameter int PS_W     = 8,
  parameter int WDT_BASE = 16  // slow ticks per unprescaled period, >= 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_tick,
  input  logic          ext_pin,
  input  logic          wdt_tick,
  input  logic          wdt_en,
  input  logic          wdt_clr,
  input  logic          sleep_req,
  input  logic          mode_we,
  input  logic [5:0]    mode_wdata,
  input  logic          tmr_we,
  input  logic [TW-1:0] tmr_wdata,
  output logic [TW-1:0] tmr_q,
  output logic          wdt_timeout
);
  import tw_pkg::*;

  logic [1:0] rst_sync;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  tw_mode_t      mode_q, mode_d;
  logic [TW-1:0] tmr_d;
  logic          edge_evt, src_evt, wdt_raw, wd_kick;
  logic          ps_adv, ps_clr, ps_fire, tmr_inc, wdt_evt;

  tw_edge_sync u_sync (
    .clk(clk), .rst_n(rst_i_n), .pin_in(ext_pin),
    .fall_sel(mode_q.edge_fall), .edge_evt(edge_evt)
  );

  always_comb begin
    src_evt = mode_q.src_ext ? edge_evt : cyc_tick;
    wdt_raw = wdt_tick & wdt_en;
    wd_kick = wdt_clr | sleep_req;
    ps_adv  = mode_q.ps_to_wdt ? wdt_raw : src_evt;
    ps_clr  = mode_q.ps_to_wdt ? wd_kick : tmr_we;
  end

  tw_prescaler #(.PS_W(PS_W)) u_ps (
    .clk(clk), .rst_n(rst_i_n), .adv(ps_adv), .clr(ps_clr),
    .sel(mode_q.ps_sel), .wdt_side(mode_q.ps_to_wdt), .fire(ps_fire)
  );

  always_comb begin
    tmr_inc = mode_q.ps_to_wdt ? src_evt : ps_fire;
    wdt_evt = mode_q.ps_to_wdt ? ps_fire : wdt_raw;
  end

  tw_wdt #(.BASE(WDT_BASE)) u_wdt (
    .clk(clk), .rst_n(rst_i_n), .en(wdt_en), .evt(wdt_evt),
    .clr(wd_kick), .timeout(wdt_timeout)
  );

  always_comb begin
    mode_d = mode_we ? tw_mode_t'(mode_wdata) : mode_q;
    if (tmr_we)       tmr_d = tmr_wdata;
    else if (tmr_inc) tmr_d = tmr_q + 1'b1;
    else              tmr_d = tmr_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      mode_q <= TW_MODE_RST;
      tmr_q  <= '0;
    end else begin
      mode_q <= mode_d;
      tmr_q  <= tmr_d;
    end
  end
endmodule

// File: rtl/tw_chk.sv
module tw_chk #(
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wdt_en,
  input logic          wdt_clr,
  input logic          sleep_req,
  input logic          tmr_we,
  input logic [TW-1:0] tmr_wdata,
  input logic [TW-1:0] tmr_q,
  input logic          wdt_timeout
);
  // R7: the time-out is a single-cycle pulse
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_timeout |=> !wdt_timeout);

  // R6: a write shows up on the next clock
  a_r6_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_we |=> (tmr_q == $past(tmr_wdata)));

  // R2: without a write the timer holds or steps by exactly one
  a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_we |=> (tmr_q == $past(tmr_q) || tmr_q == TW'($past(tmr_q) + 1'b1)));

  // R8: a clear or sleep strobe suppresses the next time-out
  a_r8_kick_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_clr || sleep_req) |=> !wdt_timeout);

  // R8: a disabled watchdog never times out
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_en |=> !wdt_timeout);
endmodule

bind tmr_wdt_top tw_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wdt_en(wdt_en), .wdt_clr(wdt_clr),
  .sleep_req(sleep_req), .tmr_we(tmr_we), .tmr_wdata(tmr_wdata),
  .tmr_q(tmr_q), .wdt_timeout(wdt_timeout)
);

// File: tb/tmr_wdt_top_tb_top.sv
module tmr_wdt_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_tick = 0, ext_pin = 0, wdt_tick = 0, wdt_en = 0;
  logic       wdt_clr = 0, sleep_req = 0, mode_we = 0, tmr_we = 0;
  logic [5:0] mode_wdata = 0;
  logic [7:0] tmr_wdata = 0;
  logic [7:0] tmr_q;
  logic       wdt_timeout;

  int total = 0;
  int bad = 0;
  bit live = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_wdt_top #(.TW(8), .PS_W(8), .WDT_BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .ext_pin(ext_pin),
    .wdt_tick(wdt_tick), .wdt_en(wdt_en), .wdt_clr(wdt_clr),
    .sleep_req(sleep_req), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .tmr_we(tmr_we), .tmr_wdata(tmr_wdata), .tmr_q(tmr_q),
    .wdt_timeout(wdt_timeout)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_mode, m_ps, m_tmr, m_wc, m_to, p1, p2, p3;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 63; m_ps = 0; m_tmr = 0; m_wc = 0; m_to = 0;
      p1 = 0; p2 = 0; p3 = 0;
    end else begin
      int code, ratio;
      bit ext, fall, towdt, edge_ev, src, wraw, adv, clr, fire, tinc, wev;
      ext   = m_mode[5];
      fall  = m_mode[4];
      towdt = m_mode[3];
      code  = m_mode & 7;
      ratio = towdt ? (1 << code) : (2 << code);
      edge_ev = fall ? (p2 == 0 && p3 == 1) : (p2 == 1 && p3 == 0);
      src   = ext ? edge_ev : cyc_tick;
      wraw  = wdt_tick && wdt_en;
      adv   = towdt ? wraw : src;
      clr   = towdt ? (wdt_clr || sleep_req) : tmr_we;
      fire  = adv && (((m_ps + 1) % ratio) == 0);
      tinc  = towdt ? src : fire;
      wev   = towdt ? fire : wraw;
      if (clr) m_ps = 0;
      else if (adv) m_ps = (m_ps + 1) % 256;
      if (tmr_we) m_tmr = tmr_wdata;
      else if (tinc) m_tmr = (m_tmr + 1) % 256;
      m_to = 0;
      if (wdt_clr || sleep_req || !wdt_en) m_wc = 0;
      else if (wev) begin
        if (m_wc == BASE - 1) begin m_wc = 0; m_to = 1; end
        else m_wc++;
      end
      if (mode_we) m_mode = mode_wdata;
      p3 = p2; p2 = p1; p1 = ext_pin;
    end
  end

  // Per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (live) begin
      chk("R4 timer vs model", tmr_q, m_tmr);
      chk("R7 timeout vs model", wdt_timeout, m_to);
    end
  end

  task automatic idle();
    cyc_tick = 0; wdt_tick = 0; wdt_clr = 0; sleep_req = 0;
    mode_we = 0; tmr_we = 0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_mode(input logic [5:0] m);
    @(negedge clk); idle(); mode_we = 1; mode_wdata = m;
    @(negedge clk); idle();
  endtask

  task automatic wr_tmr(input logic [7:0] v);
    @(negedge clk); idle(); tmr_we = 1; tmr_wdata = v;
    @(negedge clk); idle();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); idle(); cyc_tick = 1;
    end
    @(negedge clk); idle();
  endtask

  task automatic pin_toggles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_pin = ~ext_pin;
      step(2);
    end
    step(4);
  endtask

  // Kick with clear (or sleep), then count slow ticks until the pulse
  task automatic measure_wdt(input bit use_sleep, output int n);
    @(negedge clk); idle();
    if (use_sleep) sleep_req = 1; else wdt_clr = 1;
    @(negedge clk); idle(); wdt_tick = 1;
    n = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      n++;
      if (wdt_timeout) break;
    end
    idle();
  endtask

  initial begin : watchdog_timer
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int n;
    step(3);
    rst_n = 1;
    step(4);
    live = 1;
    // R1: reset state and default mode
    chk("R1 timer reset", tmr_q, 0);
    chk("R1 timeout reset", wdt_timeout, 0);
    ticks(10);
    chk("R1 cycle ticks ignored under default external mode", tmr_q, 0);

    // R4: prescaler on timer, 1:2 then 1:16
    set_mode(6'b000_000);
    wr_tmr(8'h00);
    ticks(20);
    chk("R4 ratio 1:2", tmr_q, 10);
    set_mode(6'b000_011);
    wr_tmr(8'h00);
    ticks(64);
    chk("R4 ratio 1:16", tmr_q, 4);

    // R6: write clears timer-side prescaler
    ticks(9);
    wr_tmr(8'h20);
    ticks(15);
    chk("R6 write cleared prescaler", tmr_q, 8'h20);
    ticks(1);
    chk("R6 count after cleared prescaler", tmr_q, 8'h21);

    // R2/R5/R6: prescaler on watchdog, timer direct, wrap
    set_mode(6'b001_000);
    wr_tmr(8'hFD);
    ticks(5);
    chk("R2 R6 direct count and wrap", tmr_q, 8'h02);

    // R3: external rising then falling
    set_mode(6'b101_000);
    wr_tmr(8'h00);
    ext_pin = 0; step(4);
    pin_toggles(8);
    chk("R3 rising edges", tmr_q, 4);
    set_mode(6'b111_000);
    wr_tmr(8'h00);
    pin_toggles(6);
    chk("R3 falling edges", tmr_q, 3);

    // R7: watchdog periods
    wdt_en = 1;
    set_mode(6'b001_000);
    measure_wdt(0, n);
    chk("R7 period ratio 1:1", n, BASE);
    set_mode(6'b001_010);
    measure_wdt(0, n);
    chk("R5 R7 period ratio 1:4", n, BASE * 4);
    set_mode(6'b000_010);
    measure_wdt(0, n);
    chk("R5 R7 unprescaled when on timer", n, BASE);

    // R8: partial progress discarded by clear and by sleep
    set_mode(6'b001_111);
    for (int i = 0; i < 300; i++) begin @(negedge clk); wdt_tick = 1; end
    measure_wdt(0, n);
    chk("R8 clear restarts full 1:128 period", n, BASE * 128);
    for (int i = 0; i < 77; i++) begin @(negedge clk); wdt_tick = 1; end
    measure_wdt(1, n);
    chk("R8 sleep restarts full period", n, BASE * 128);

    // R8: disabled watchdog stays silent
    set_mode(6'b001_000);
    wdt_en = 0;
    n = 0;
    for (int i = 0; i < 4 * BASE; i++) begin
      @(negedge clk); wdt_tick = 1;
      if (wdt_timeout) n++;
    end
    @(negedge clk); idle();
    chk("R8 disabled no timeout", n, 0);

    // Random mix against the model
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      idle();
      cyc_tick  = ($urandom % 2) == 0;
      wdt_tick  = ($urandom % 2) == 0;
      wdt_en    = ($urandom % 16) != 0;
      wdt_clr   = ($urandom % 300) == 0;
      sleep_req = ($urandom % 500) == 0;
      tmr_we    = ($urandom % 60) == 0;
      tmr_wdata = 8'($urandom);
      if (($urandom % 3) == 0) ext_pin = ~ext_pin;
      if (($urandom % 200) == 0) begin
        mode_we = 1; mode_wdata = 6'($urandom);
      end
    end
    @(negedge clk); idle();
    step(4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule